// File: doc/BRIEF.md
# Aliased Floating-Point and Vector Register File

This block holds 32 architectural registers in one physical array whose entries are 256 bits wide. Three views of different widths share that array. The scalar floating-point view is 64 bits wide, the short-vector view is 128 bits wide, and the long-vector view is 256 bits wide. Every view uses the same 5-bit register index. Each narrow view is mapped onto the low-order bits of the wider view. As a result, register n in the 64-bit view is bits [63:0] of entry n, and register n in the 128-bit view is bits [127:0] of entry n.

The block has two combinational read ports and one write port. A 2-bit view code on every port selects the width of the access. The codes are 0 for 64 bits, 1 for 128 bits, 2 for 256 bits, and 3 for no access. A narrow write changes only its own slice of the entry. A narrow read returns the low slice of the entry, zero-extended to 256 bits. A write takes effect at the rising clock edge. A read of the index being written in the same cycle sees the merged value, in which only the slice covered by the write view is replaced.

Top module: `fvrf_top`

## Requirements
- R1: There are 32 entries selected by a 5-bit index. A write with view code 2 replaces all 256 bits of the entry, and a later read of that index with view code 2 returns those 256 bits.
- R2: A write with view code 0 replaces bits [63:0] of the entry and leaves bits [255:64] unchanged.
- R3: A write with view code 1 replaces bits [127:0] of the entry and leaves bits [255:128] unchanged.
- R4: A write with view code 3 changes no entry.
- R5: A read with view code 0 returns bits [63:0] of the entry, with bits [255:64] of the port at zero.
- R6: A read with view code 1 returns bits [127:0] of the entry, with bits [255:128] of the port at zero.
- R7: A read with view code 3 returns all zeros.
- R8: A read whose index matches an active write in the same cycle returns the merged new value. Only the slice covered by the write view is taken from the write data, and the read view is applied afterwards.
- R9: Each read port selects its own index and view, independently of the other read port.
- R10: An active-low reset, asserted asynchronously, clears every bit of every entry to zero.
- R11: While `wr_en` is low, no entry changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Register index for the write |
| wr_view | input | 2 | Write view code (0: 64, 1: 128, 2: 256, 3: none) |
| wr_data | input | 256 | Write data; only the low slice named by the view is used |
| rd0_idx | input | 5 | Register index for read port 0 |
| rd0_view | input | 2 | Read view code for port 0 |
| rd0_data | output | 256 | Read data for port 0, zero-extended |
| rd1_idx | input | 5 | Register index for read port 1 |
| rd1_view | input | 2 | Read view code for port 1 |
| rd1_data | output | 256 | Read data for port 1, zero-extended |

## Verification
A slice register that loads when it should not appears at the ports as corrupted upper bits. This shows on the first later read of that entry with a wider view, so the bench mixes narrow writes with wide reads of the same index. A fault in the forwarding merge or in the write decode shows in the same cycle on a read that hits the write. A wrong view mask shows as non-zero high bits on any narrow read. Because the reference model is compared on every clock, the first cycle that exposes a bad value reports it.

// File: rtl/fvrf_pkg.sv
package fvrf_pkg;

  typedef enum logic [1:0] {
    VIEW_FP   = 2'd0,
    VIEW_SV   = 2'd1,
    VIEW_LV   = 2'd2,
    VIEW_NONE = 2'd3
  } view_e;

  localparam int NSLICE = 3;

  // slice s is covered by a view when the view reaches that slice
  function automatic logic [NSLICE-1:0] view_mask(input logic [1:0] code);
    logic [NSLICE-1:0] m;
    case (view_e'(code))
      VIEW_FP: m = 3'b001;
      VIEW_SV: m = 3'b011;
      VIEW_LV: m = 3'b111;
      default: m = 3'b000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fvrf_wr_decode.sv
module fvrf_wr_decode
  import fvrf_pkg::*;
#(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_view,
  output logic [N-1:0]      ent_en,
  output logic [NSLICE-1:0] slice_mask
);

  always_comb begin
    slice_mask = wr_en ? view_mask(wr_view) : '0;
  end

  for (genvar e = 0; e < N; e++) begin : g_ent
    always_comb begin
      ent_en[e] = (wr_idx == IDX_W'(e)) && (|slice_mask);
    end
  end

endmodule

// File: rtl/fvrf_storage.sv
module fvrf_storage
  import fvrf_pkg::*;
#(
  parameter int N    = 32,
  parameter int FP_W = 64,
  parameter int SV_W = 128,
  parameter int LV_W = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            ent_en,
  input  logic [NSLICE-1:0]       slice_mask,
  input  logic [LV_W-1:0]         wr_data,
  output logic [N-1:0][LV_W-1:0]  entries
);

  for (genvar e = 0; e < N; e++) begin : g_ent
    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      localparam int LO = (s == 0) ? 0 : ((s == 1) ? FP_W : SV_W);
      localparam int HI = (s == 0) ? FP_W - 1 : ((s == 1) ? SV_W - 1 : LV_W - 1);
      localparam int W  = HI - LO + 1;

      logic         ce;
      logic [W-1:0] d;
      logic [W-1:0] q;

      // next-state
      always_comb begin
        ce = ent_en[e] & slice_mask[s];
        d  = wr_data[HI:LO];
      end

      // register
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (ce) begin
          q <= d;
        end
      end

      assign entries[e][HI:LO] = q;
    end
  end

endmodule

// File: rtl/fvrf_read_port.sv
module fvrf_read_port
  import fvrf_pkg::*;
#(
  parameter int N     = 32,
  parameter int IDX_W = 5,
  parameter int FP_W  = 64,
  parameter int SV_W  = 128,
  parameter int LV_W  = 256
) (
  input  logic [N-1:0][LV_W-1:0]  entries,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [1:0]              rd_view,
  input  logic [N-1:0]            wr_ent_en,
  input  logic [NSLICE-1:0]       wr_slice_mask,
  input  logic [LV_W-1:0]         wr_data,
  output logic [LV_W-1:0]         rd_data
);

  logic [LV_W-1:0]   raw;
  logic              hit;
  logic [NSLICE-1:0] rmask;

  always_comb begin
    raw   = entries[rd_idx];
    hit   = wr_ent_en[rd_idx];
    rmask = view_mask(rd_view);
  end

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    localparam int LO = (s == 0) ? 0 : ((s == 1) ? FP_W : SV_W);
    localparam int HI = (s == 0) ? FP_W - 1 : ((s == 1) ? SV_W - 1 : LV_W - 1);

    logic [HI-LO:0] merged;

    always_comb begin
      merged = (hit && wr_slice_mask[s]) ? wr_data[HI:LO] : raw[HI:LO];
    end

    assign rd_data[HI:LO] = rmask[s] ? merged : '0;
  end

endmodule

// File: rtl/fvrf_top.sv
module fvrf_top
  import fvrf_pkg::*;
#(
  parameter int N     = 32,
  parameter int IDX_W = 5,
  parameter int FP_W  = 64,
  parameter int SV_W  = 128,
  parameter int LV_W  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_view,
  input  logic [LV_W-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic [1:0]       rd0_view,
  output logic [LV_W-1:0]  rd0_data,
  input  logic [IDX_W-1:0] rd1_idx,
  input  logic [1:0]       rd1_view,
  output logic [LV_W-1:0]  rd1_data
);

  logic [N-1:0]            ent_en;
  logic [NSLICE-1:0]       slice_mask;
  logic [N-1:0][LV_W-1:0]  entries;

  fvrf_wr_decode #(.N(N), .IDX_W(IDX_W)) u_dec (
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_view    (wr_view),
    .ent_en     (ent_en),
    .slice_mask (slice_mask)
  );

  fvrf_storage #(.N(N), .FP_W(FP_W), .SV_W(SV_W), .LV_W(LV_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_en     (ent_en),
    .slice_mask (slice_mask),
    .wr_data    (wr_data),
    .entries    (entries)
  );

  fvrf_read_port #(.N(N), .IDX_W(IDX_W), .FP_W(FP_W), .SV_W(SV_W), .LV_W(LV_W)) u_rd0 (
    .entries       (entries),
    .rd_idx        (rd0_idx),
    .rd_view       (rd0_view),
    .wr_ent_en     (ent_en),
    .wr_slice_mask (slice_mask),
    .wr_data       (wr_data),
    .rd_data       (rd0_data)
  );

  fvrf_read_port #(.N(N), .IDX_W(IDX_W), .FP_W(FP_W), .SV_W(SV_W), .LV_W(LV_W)) u_rd1 (
    .entries       (entries),
    .rd_idx        (rd1_idx),
    .rd_view       (rd1_view),
    .wr_ent_en     (ent_en),
    .wr_slice_mask (slice_mask),
    .wr_data       (wr_data),
    .rd_data       (rd1_data)
  );

endmodule

// File: rtl/fvrf_checker.sv
module fvrf_checker #(
  parameter int IDX_W = 5,
  parameter int FP_W  = 64,
  parameter int SV_W  = 128,
  parameter int LV_W  = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [1:0]       wr_view,
  input logic [LV_W-1:0]  wr_data,
  input logic [IDX_W-1:0] rd0_idx,
  input logic [1:0]       rd0_view,
  input logic [LV_W-1:0]  rd0_data,
  input logic [IDX_W-1:0] rd1_idx,
  input logic [1:0]       rd1_view,
  input logic [LV_W-1:0]  rd1_data
);

  assert_fp_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_view == 2'd0 |-> rd0_data[LV_W-1:FP_W] == '0);

  assert_sv_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd1_view == 2'd1 |-> rd1_data[LV_W-1:SV_W] == '0);

  assert_none_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_view == 2'd3 |-> rd0_data == '0);

  assert_fwd_lv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_view == 2'd2 && rd1_view == 2'd2 && rd1_idx == wr_idx)
      |-> rd1_data == wr_data);

  assert_fwd_fp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_view == 2'd0 && rd0_view == 2'd0 && rd0_idx == wr_idx)
      |-> rd0_data[FP_W-1:0] == wr_data[FP_W-1:0]);

  // a 64-bit write is visible on the next cycle when nothing rewrites it
  assert_fp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && wr_view == 2'd0) && $past(wr_idx) == rd0_idx &&
     rd0_view == 2'd0 && !(wr_en && wr_idx == rd0_idx))
      |-> rd0_data[FP_W-1:0] == $past(wr_data[FP_W-1:0]));

endmodule

bind fvrf_top fvrf_checker #(.IDX_W(IDX_W), .FP_W(FP_W), .SV_W(SV_W), .LV_W(LV_W)) u_chk (.*);

// File: tb/sim_fvrf_top.sv
module sim_fvrf_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [4:0]   wr_idx;
  logic [1:0]   wr_view;
  logic [255:0] wr_data;
  logic [4:0]   rd0_idx;
  logic [1:0]   rd0_view;
  logic [255:0] rd0_data;
  logic [4:0]   rd1_idx;
  logic [1:0]   rd1_view;
  logic [255:0] rd1_data;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;
  logic [255:0] mdl [32];

  always #10 clk = ~clk;

  fvrf_top u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data),
    .rd0_idx(rd0_idx), .rd0_view(rd0_view), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_view(rd1_view), .rd1_data(rd1_data)
  );

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [255:0] merge(input logic [255:0] old, input logic [255:0] d,
                                         input logic [1:0] v);
    logic [255:0] r = old;
    if (v == 2'd0) r[63:0] = d[63:0];
    else if (v == 2'd1) r[127:0] = d[127:0];
    else if (v == 2'd2) r = d;
    return r;
  endfunction

  function automatic logic [255:0] expect_rd(input logic [4:0] idx, input logic [1:0] v);
    logic [255:0] e = mdl[idx];
    if (rst_n && wr_en && wr_idx == idx) e = merge(e, wr_data, wr_view);
    if (v == 2'd0) return {192'd0, e[63:0]};
    if (v == 2'd1) return {128'd0, e[127:0]};
    if (v == 2'd2) return e;
    return '0;
  endfunction

  task automatic chk(input string tag, input int port, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s port%0d: actual %h expected %h", tag, port, act, exp);
    end
  endtask

  // inputs already applied; check mid-cycle, then let the edge happen
  task automatic cyc(input string tag);
    #5;
    chk(tag, 0, rd0_data, expect_rd(rd0_idx, rd0_view));
    chk(tag, 1, rd1_data, expect_rd(rd1_idx, rd1_view));
    @(posedge clk);
    #1;
    if (rst_n && wr_en) mdl[wr_idx] = merge(mdl[wr_idx], wr_data, wr_view);
  endtask

  task automatic set_wr(input logic en, input logic [4:0] idx, input logic [1:0] v,
                        input logic [255:0] d);
    wr_en = en; wr_idx = idx; wr_view = v; wr_data = d;
  endtask

  task automatic set_rd(input logic [4:0] i0, input logic [1:0] v0,
                        input logic [4:0] i1, input logic [1:0] v1);
    rd0_idx = i0; rd0_view = v0; rd1_idx = i1; rd1_view = v1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    rst_n = 1'b0;
    set_wr(1'b0, 5'd0, 2'd0, '0);
    set_rd(5'd0, 2'd2, 5'd1, 2'd2);
    repeat (3) @(posedge clk);
    #4 rst_n = 1'b1;
    @(posedge clk); #1;

    // R10: every entry reads zero after reset
    for (int i = 0; i < 32; i += 2) begin
      set_rd(5'(i), 2'd2, 5'(i + 1), 2'd2);
      cyc("R10 reset zero");
    end

    // R1: full-width writes to every index, read back next cycle
    for (int i = 0; i < 32; i++) begin
      set_wr(1'b1, 5'(i), 2'd2, rnd256());
      set_rd(5'(i), 2'd2, 5'((i + 31) % 32), 2'd2);
      cyc("R1 full write");
    end
    set_wr(1'b0, 5'd0, 2'd0, '0);
    for (int i = 0; i < 32; i += 2) begin
      set_rd(5'(i), 2'd2, 5'(i + 1), 2'd2);
      cyc("R1 full readback");
    end

    // R2: 64-bit write keeps upper bits; R5 narrow read
    set_wr(1'b1, 5'd3, 2'd0, rnd256()); set_rd(5'd4, 2'd2, 5'd3, 2'd0); cyc("R2 fp write");
    set_wr(1'b0, 5'd3, 2'd0, rnd256()); set_rd(5'd3, 2'd2, 5'd3, 2'd0); cyc("R2 R5 fp readback");

    // R3: 128-bit write keeps upper bits; R6 narrow read
    set_wr(1'b1, 5'd7, 2'd1, rnd256()); set_rd(5'd0, 2'd1, 5'd1, 2'd0); cyc("R3 sv write");
    set_wr(1'b0, 5'd7, 2'd1, rnd256()); set_rd(5'd7, 2'd2, 5'd7, 2'd1); cyc("R3 R6 sv readback");

    // R4: view code 3 write is ignored
    set_wr(1'b1, 5'd9, 2'd3, rnd256()); set_rd(5'd9, 2'd2, 5'd9, 2'd1); cyc("R4 none write");
    set_wr(1'b0, 5'd9, 2'd0, '0);       set_rd(5'd9, 2'd2, 5'd9, 2'd0); cyc("R4 none readback");

    // R11: wr_en low is ignored
    set_wr(1'b0, 5'd11, 2'd2, rnd256()); set_rd(5'd11, 2'd2, 5'd12, 2'd2); cyc("R11 disabled write");
    set_wr(1'b0, 5'd11, 2'd2, '0);       set_rd(5'd11, 2'd2, 5'd11, 2'd1); cyc("R11 readback");

    // R7: view code 3 reads zero
    set_rd(5'd5, 2'd3, 5'd6, 2'd3); cyc("R7 none read");

    // R8: same-cycle forwarding across view combinations
    for (int wv = 0; wv < 4; wv++) begin
      for (int rv = 0; rv < 4; rv++) begin
        set_wr(1'b1, 5'(13 + wv), 2'(wv), rnd256());
        set_rd(5'(13 + wv), 2'(rv), 5'(13 + wv), 2'd2);
        cyc("R8 forward");
      end
    end

    // R9: ports read different indices and views at once
    set_wr(1'b0, 5'd0, 2'd0, '0);
    for (int i = 0; i < 16; i++) begin
      set_rd(5'(i), 2'(i % 4), 5'(31 - i), 2'((i + 2) % 4));
      cyc("R9 independent ports");
    end

    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      set_wr(1'($urandom), 5'($urandom), 2'($urandom), rnd256());
      set_rd(5'($urandom), 2'($urandom), 5'($urandom), 2'($urandom));
      if ($urandom % 3 == 0) rd0_idx = wr_idx;
      cyc("R8 R9 mixed");
    end

    // R10: reset again after data is present
    set_wr(1'b0, 5'd0, 2'd0, '0);
    #3 rst_n = 1'b0;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    @(posedge clk); #1;
    #4 rst_n = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < 32; i += 2) begin
      set_rd(5'(i), 2'd2, 5'(i + 1), 2'd2);
      cyc("R10 second reset");
    end

    finish_run();
  end

endmodule